// File: doc/BRIEF.md
# One-Time-Programmable Serial Memory Programming Controller

This block models the programming side of a one-time-programmable serial configuration memory that holds 32-bit words. The memory has a single shared data line. A four-level supply input, already digitised to normal, access and program levels, takes the controller into programming mode. This happens only after a fixed entry sequence has been recognised. Once in the mode, the chip-enable and output-enable inputs select what each rising clock edge does: shift a bit into the word latch, shift a bit of the addressed word out, or step the word address.

A word is burned only by a timed program pulse, which means holding the supply at program level for a parameterised number of clock cycles. Burning can only clear bits. A latch that still holds all ones is treated as "nothing to program" and is skipped. The word one past the last data word stores the reset-polarity setting. The chip-enable output reports that setting while the mode is active. The output floats whenever the supply sits at program level. Removing power is modelled by a power-off level. Asserting it with both enables low leaves the mode and keeps the array contents.

Top module: `otp_pgm_ctrl`

## Requirements
- R1: After `rst_n` is released, `prog_mode`, `data_oe` and `burned` are 0, `ceo` and `ceo_oe` are 1, and every array word (including the polarity word) reads all ones.
- R2: The controller sets `prog_mode` after three rising edges with `ce`=`oe`=1 and `pwr_off`=0: two consecutive edges with `vpp_level`=2 (program), then one edge with `vpp_level`=1 (access). `prog_mode` is 1 right after that third edge. Levels 0 and 3 both mean normal.
- R3: A sequence that breaks is discarded and the detector returns to idle without entering. A break is any of: normal level, `ce` or `oe` low, `pwr_off` high, or access level after only one program edge.
- R4: In the mode, with the level not at program and `ce`=1, `oe`=1, each edge shifts `data_in` into the word latch from bit 0 upward. After 32 edges, the first bit sent sits at bit 31.
- R5: In the mode, with the level not at program and `ce`=0, `oe`=1, `data_oe` is 1 and `data_out` shows bit 31−k of the addressed word after k such edges. The bit index wraps from bit 0 back to bit 31.
- R6: In the mode, an edge with `ce`=1, `oe`=0 advances the word address by one and restarts readback at bit 31. The address runs from 0 to DEPTH, where DEPTH is the polarity word, and then wraps to 0. Entry sets the address to 0.
- R7: An edge in the mode with `ce`=0 sets the word latch to all ones. It does this whether `oe` is high or low, so the loaded word is discarded.
- R8: With the mode active, holding program level for PGM_CYCLES consecutive edges burns the latch into the addressed word on the last of those edges. `burned` is 1 for exactly the next cycle. A shorter pulse changes nothing, and one pulse burns at most once.
- R9: A latch holding all ones is skipped: no `burned` pulse and the word is unchanged.
- R10: A burn stores the stored word ANDed with the latch, so array bits only move from 1 to 0.
- R11: Inside the mode, `ceo` is 0 when the polarity word (address DEPTH) is all zeros and 1 otherwise. Outside the mode, `ceo` is 1.
- R12: `ceo_oe` is 0 whenever `vpp_level` is 2, and 1 otherwise.
- R13: An edge in the mode with `ce`=0, `oe`=0 and `pwr_off`=1 clears `prog_mode`, and `data_oe` then stays 0. The array keeps its contents through this exit and a later re-entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low initialise (blank array) |
| ce | input | 1 | Chip enable |
| oe | input | 1 | Output enable |
| vpp_level | input | 2 | Supply level: 0 normal, 1 access, 2 program, 3 normal |
| data_in | input | 1 | Serial data into the word latch |
| pwr_off | input | 1 | Power-removed level |
| data_out | output | 1 | Serial data read from the addressed word |
| data_oe | output | 1 | Drive enable for the data line |
| ceo | output | 1 | Chip-enable output / polarity report |
| ceo_oe | output | 1 | Drive enable for `ceo` |
| prog_mode | output | 1 | Programming mode active |
| pulse_active | output | 1 | Program level present while in the mode |
| burned | output | 1 | One-cycle flag after a word is burned |

## Verification
The assertions assume the supply level, enables and data change only between clock edges and stay stable at each rising edge. They also assume `rst_n` is held low for at least one edge before any sequence starts. The bench drives every input on the falling edge and samples on the falling edge one cycle later, so each checked edge sees settled values. It follows the same ordering the real flow uses: it clears the latch, loads 32 bits, pulses, and then steps or reads. Separate tasks run the interrupted entries and the short and skipped pulses.

// File: rtl/otp_pgm_pkg.sv
package otp_pgm_pkg;
   typedef enum logic [1:0] {
      LVL_NORMAL  = 2'd0,
      LVL_ACCESS  = 2'd1,
      LVL_PROGRAM = 2'd2,
      LVL_RSVD    = 2'd3
   } supply_lvl_e;

   typedef enum logic [1:0] {
      ENT_IDLE = 2'd0,
      ENT_ONE  = 2'd1,
      ENT_TWO  = 2'd2
   } entry_st_e;
endpackage

// File: rtl/otp_pgm_entry_det.sv
module otp_pgm_entry_det
   import otp_pgm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ce,
   input  logic oe,
   input  logic lvl_prog,
   input  logic lvl_access,
   input  logic pwr_off,
   output logic enter,
   output logic mode
);
   entry_st_e st_q;
   logic      both_hi;

   assign both_hi = ce && oe && !pwr_off;
   assign enter   = !mode && (st_q == ENT_TWO) && both_hi && lvl_access;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ENT_IDLE;
         mode <= 1'b0;
      end else if (mode) begin
         st_q <= ENT_IDLE;
         if (!ce && !oe && pwr_off) mode <= 1'b0;
      end else if (enter) begin
         st_q <= ENT_IDLE;
         mode <= 1'b1;
      end else if (both_hi && lvl_prog) begin
         st_q <= (st_q == ENT_IDLE) ? ENT_ONE : ENT_TWO;
      end else begin
         st_q <= ENT_IDLE;
      end
   end
endmodule

// File: rtl/otp_pgm_pulse_timer.sv
module otp_pgm_pulse_timer #(
   parameter int PGM_CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic fire
);
   localparam int CNT_W = (PGM_CYCLES < 2) ? 1 : $clog2(PGM_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PGM_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   assign fire = active && !done_q && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!active) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (fire) begin
         done_q <= 1'b1;
      end else if (!done_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/otp_pgm_word_store.sv
module otp_pgm_word_store #(
   parameter int WORD_W    = 32,
   parameter int DEPTH     = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode,
   input  logic enter,
   input  logic lvl_prog,
   input  logic fire,
   input  logic ce,
   input  logic oe,
   input  logic data_in,
   output logic rd_bit,
   output logic pol_hi,
   output logic burned
);
   localparam int ROWS   = DEPTH + 1;
   localparam int ADDR_W = $clog2(ROWS);
   localparam int BIT_W  = (WORD_W < 2) ? 1 : $clog2(WORD_W);
   localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(DEPTH);
   localparam logic [BIT_W-1:0]  BIT_TOP  = BIT_W'(WORD_W - 1);

   logic [WORD_W-1:0] arr_q [ROWS];
   logic [WORD_W-1:0] latch_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BIT_W-1:0]  oidx_q;
   logic [BIT_W-1:0]  sel_bit;
   logic              do_burn;
   logic              op_shift, op_read, op_step, op_clear;

   assign op_shift = mode && !lvl_prog && ce && oe;
   assign op_read  = mode && !lvl_prog && !ce && oe;
   assign op_step  = mode && !lvl_prog && ce && !oe;
   assign op_clear = mode && !lvl_prog && !ce;
   assign do_burn  = mode && lvl_prog && fire && (latch_q != '1);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            arr_q[r] <= '1;
         else if (do_burn && (addr_q == ADDR_W'(r)))
            arr_q[r] <= arr_q[r] & latch_q;
      end
   end

   if (MSB_FIRST) begin : g_msb
      assign sel_bit = BIT_TOP - oidx_q;
   end else begin : g_lsb
      assign sel_bit = oidx_q;
   end

   assign rd_bit = arr_q[addr_q][sel_bit];
   assign pol_hi = |arr_q[DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '1;
         addr_q  <= '0;
         oidx_q  <= '0;
         burned  <= 1'b0;
      end else begin
         burned <= do_burn;
         if (enter) begin
            latch_q <= '1;
            addr_q  <= '0;
            oidx_q  <= '0;
         end else begin
            if (op_shift) begin
               if (MSB_FIRST) latch_q <= {latch_q[WORD_W-2:0], data_in};
               else           latch_q <= {data_in, latch_q[WORD_W-1:1]};
            end else if (op_clear) begin
               latch_q <= '1;
            end
            if (op_read)
               oidx_q <= (oidx_q == BIT_TOP) ? '0 : oidx_q + 1'b1;
            if (op_step) begin
               addr_q <= (addr_q == ADDR_TOP) ? '0 : addr_q + 1'b1;
               oidx_q <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/otp_pgm_ctrl.sv
module otp_pgm_ctrl
   import otp_pgm_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int DEPTH      = 16,
   parameter int PGM_CYCLES = 5000,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce,
   input  logic       oe,
   input  logic [1:0] vpp_level,
   input  logic       data_in,
   input  logic       pwr_off,
   output logic       data_out,
   output logic       data_oe,
   output logic       ceo,
   output logic       ceo_oe,
   output logic       prog_mode,
   output logic       pulse_active,
   output logic       burned
);
   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end
   if (PGM_CYCLES < 1) begin : g_bad_pgm
      $error("PGM_CYCLES must be at least 1");
   end

   logic lvl_prog, lvl_access, enter, fire, rd_bit, pol_hi;

   assign lvl_prog   = (supply_lvl_e'(vpp_level) == LVL_PROGRAM);
   assign lvl_access = (supply_lvl_e'(vpp_level) == LVL_ACCESS);

   otp_pgm_entry_det u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce         (ce),
      .oe         (oe),
      .lvl_prog   (lvl_prog),
      .lvl_access (lvl_access),
      .pwr_off    (pwr_off),
      .enter      (enter),
      .mode       (prog_mode)
   );

   otp_pgm_pulse_timer #(.PGM_CYCLES(PGM_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (pulse_active),
      .fire   (fire)
   );

   otp_pgm_word_store #(
      .WORD_W    (WORD_W),
      .DEPTH     (DEPTH),
      .MSB_FIRST (MSB_FIRST)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (prog_mode),
      .enter    (enter),
      .lvl_prog (lvl_prog),
      .fire     (fire),
      .ce       (ce),
      .oe       (oe),
      .data_in  (data_in),
      .rd_bit   (rd_bit),
      .pol_hi   (pol_hi),
      .burned   (burned)
   );

   assign pulse_active = prog_mode && lvl_prog;
   assign data_oe      = prog_mode && !lvl_prog && !ce && oe;
   assign data_out     = data_oe && rd_bit;
   assign ceo          = prog_mode ? pol_hi : 1'b1;
   assign ceo_oe       = !lvl_prog;
endmodule

// File: rtl/otp_pgm_ctrl_chk.sv
module otp_pgm_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ce,
   input logic       oe,
   input logic [1:0] vpp_level,
   input logic       pwr_off,
   input logic       data_oe,
   input logic       ceo,
   input logic       ceo_oe,
   input logic       prog_mode,
   input logic       burned
);
   assert_entry_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_mode) |-> ($past(vpp_level) == 2'd1 && $past(ce) && $past(oe) && !$past(pwr_off)));

   assert_no_entry_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_mode && vpp_level == 2'd0) |=> !prog_mode);

   assert_read_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (prog_mode && !ce && oe));

   assert_burn_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      burned |-> ($past(vpp_level) == 2'd2 && $past(prog_mode)));

   assert_single_burn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      burned |=> !burned);

   assert_ceo_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_mode |-> ceo);

   assert_ceo_float_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_level == 2'd2) |-> !ceo_oe);

   assert_exit_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_mode) |-> ($past(!ce) && $past(!oe) && $past(pwr_off)));
endmodule

bind otp_pgm_ctrl otp_pgm_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce        (ce),
   .oe        (oe),
   .vpp_level (vpp_level),
   .pwr_off   (pwr_off),
   .data_oe   (data_oe),
   .ceo       (ceo),
   .ceo_oe    (ceo_oe),
   .prog_mode (prog_mode),
   .burned    (burned)
);

// File: tb/otp_pgm_ctrl_tb_top.sv
module otp_pgm_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int PGM        = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce = 1'b1, oe = 1'b1, data_in = 1'b0, pwr_off = 1'b0;
   logic [1:0] vpp_level = 2'd0;
   logic       data_out, data_oe, ceo, ceo_oe, prog_mode, pulse_active, burned;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   localparam logic [31:0] PAT_A = 32'hA5C3_0F96;
   localparam logic [31:0] PAT_B = 32'h0FF0_F00F;
   localparam logic [31:0] PAT_C = 32'h1234_8765;

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_pgm_ctrl #(.WORD_W(32), .DEPTH(DEPTH), .PGM_CYCLES(PGM)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce(ce), .oe(oe), .vpp_level(vpp_level),
      .data_in(data_in), .pwr_off(pwr_off), .data_out(data_out),
      .data_oe(data_oe), .ceo(ceo), .ceo_oe(ceo_oe), .prog_mode(prog_mode),
      .pulse_active(pulse_active), .burned(burned)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic enter_mode();
      ce = 1; oe = 1; pwr_off = 0; vpp_level = 2'd2;
      tick(); tick();
      vpp_level = 2'd1;
      tick();
   endtask

   task automatic load_word(input logic [31:0] w);
      ce = 0; oe = 0; tick();
      ce = 1; oe = 1;
      for (int i = 0; i < 32; i++) begin
         data_in = w[31-i];
         tick();
      end
   endtask

   task automatic pulse(input int n, output int burns);
      burns = 0;
      ce = 1; oe = 1; vpp_level = 2'd2;
      for (int i = 0; i < n; i++) begin
         tick();
         if (burned) burns++;
      end
      vpp_level = 2'd1;
      tick();
      if (burned) burns++;
   endtask

   task automatic read_word(output logic [31:0] w);
      ce = 0; oe = 1;
      for (int i = 0; i < 32; i++) begin
         #1;
         w[31-i] = data_out;
         tick();
      end
      ce = 1; oe = 1;
   endtask

   task automatic step_addr(input int n);
      ce = 1; oe = 0;
      for (int i = 0; i < n; i++) tick();
      oe = 1;
   endtask

   task automatic t_reset();
      #1;
      check("R1 prog_mode", prog_mode, 0);
      check("R1 data_oe", data_oe, 0);
      check("R1 burned", burned, 0);
      check("R1 ceo", ceo, 1);
      check("R1 ceo_oe", ceo_oe, 1);
   endtask

   task automatic t_bad_entry();
      ce = 1; oe = 1; vpp_level = 2'd2; tick();
      check("R12 ceo_oe at program level", ceo_oe, 0);
      vpp_level = 2'd0; tick();
      vpp_level = 2'd1; tick();
      check("R3 normal level breaks entry", prog_mode, 0);
      vpp_level = 2'd2; tick();
      vpp_level = 2'd1; tick();
      check("R3 one program edge only", prog_mode, 0);
      vpp_level = 2'd2; tick(); tick();
      oe = 0; vpp_level = 2'd1; tick();
      check("R3 oe low breaks entry", prog_mode, 0);
      oe = 1; vpp_level = 2'd2; tick(); tick();
      pwr_off = 1; vpp_level = 2'd1; tick();
      check("R3 pwr_off breaks entry", prog_mode, 0);
      pwr_off = 0; vpp_level = 2'd0; tick();
   endtask

   task automatic t_entry();
      ce = 1; oe = 1; vpp_level = 2'd2; tick(); tick();
      check("R2 not yet after two program edges", prog_mode, 0);
      vpp_level = 2'd1; tick();
      check("R2 mode after access edge", prog_mode, 1);
      check("R12 ceo_oe at access level", ceo_oe, 1);
      check("R11 blank polarity reports high", ceo, 1);
   endtask

   task automatic t_program();
      logic [31:0] w;
      int b;
      read_word(w);
      check("R5 blank word reads ones", w, 32'hFFFF_FFFF);
      load_word(PAT_A);
      pulse(PGM, b);
      check("R8 one burn for full pulse", b, 1);
      read_word(w);
      check("R4 R5 word0 after burn", w, PAT_A);
      read_word(w);
      check("R5 readback wraps to msb", w, PAT_A);
      load_word(32'h0);
      pulse(PGM - 1, b);
      check("R8 short pulse no burn", b, 0);
      read_word(w);
      check("R8 short pulse word unchanged", w, PAT_A);
      load_word(PAT_B);
      pulse(PGM + 5, b);
      check("R8 long pulse burns once", b, 1);
      read_word(w);
      check("R10 bits only clear", w, PAT_A & PAT_B);
      load_word(32'hFFFF_FFFF);
      pulse(PGM, b);
      check("R9 all ones skipped", b, 0);
      read_word(w);
      check("R9 word unchanged after skip", w, PAT_A & PAT_B);
   endtask

   task automatic t_addr_clear();
      logic [31:0] w;
      int b;
      step_addr(1);
      read_word(w);
      check("R6 word1 blank", w, 32'hFFFF_FFFF);
      load_word(32'h0);
      ce = 0; oe = 0; tick(); ce = 1; oe = 1;
      pulse(PGM, b);
      check("R7 cleared latch gives no burn", b, 0);
      read_word(w);
      check("R7 word1 still blank", w, 32'hFFFF_FFFF);
      load_word(PAT_C);
      pulse(PGM, b);
      check("R8 word1 burn", b, 1);
      ce = 0; oe = 1;
      for (int i = 0; i < 5; i++) tick();
      step_addr(DEPTH + 1);
      read_word(w);
      check("R6 wrap to same word restarts at msb", w, PAT_C);
      step_addr(DEPTH);
      read_word(w);
      check("R6 wrap through polarity word to word0", w, PAT_A & PAT_B);
   endtask

   task automatic t_polarity();
      int b;
      step_addr(DEPTH);
      #1;
      check("R11 ceo high before polarity burn", ceo, 1);
      load_word(32'h0);
      pulse(PGM, b);
      #1;
      check("R11 ceo low for zero polarity word", ceo, 0);
      step_addr(1);
   endtask

   task automatic t_exit();
      logic [31:0] w;
      ce = 0; oe = 0; pwr_off = 1; tick();
      check("R13 mode left", prog_mode, 0);
      check("R11 ceo high outside mode", ceo, 1);
      pwr_off = 0; ce = 0; oe = 1; #1;
      check("R13 no drive outside mode", data_oe, 0);
      vpp_level = 2'd0; tick();
      enter_mode();
      check("R2 re-entry", prog_mode, 1);
      read_word(w);
      check("R13 array kept across exit", w, PAT_A & PAT_B);
      #1;
      check("R11 polarity kept", ceo, 0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_bad_entry();
      t_entry();
      t_program();
      t_addr_clear();
      t_polarity();
      t_exit();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule